// File: doc/BRIEF.md
# Serial Control-Register Port

This block gives a host microcontroller read and write access to a bank of 8-bit control registers over three wires: a serial clock, a serial input and a serial output. The serial wires are oversampled in the local clock domain. Every transaction is exactly sixteen serial clock periods long. The first byte is an address whose top bit selects the direction. The second byte is either write data taken in from the host or read data shifted back to it. A 4-bit bit counter wraps after each transaction, so transactions run back to back with no select line.

Fixed bit positions act as a guard against bit slip. In every legal address, bit 6 is clear, except for the resynchronisation address 7Fh. Every stored value has bits 7:6 equal to 01. Anything that breaks these rules is discarded and raises a sticky error flag. The host recovers from a slipped counter by sending address 7Fh followed by data FFh. The block recognises this pattern in the last sixteen bits received, wherever the counter stands, and restarts the interface without touching register contents. A separate one-cycle input restores the register defaults and spares three registers that configure the data interface.

Address bit 6 is always clear on a legal access, so only addresses 00h to 3Fh are stored. The power-up value of register `n` is `{2'b01, n[5:0]}`.

Top module: `csr_serial_slave`

## Requirements
- R1: While `rst_n` is low and after it returns high, every register holds its default `{2'b01, addr[5:0]}`, `sdo` is 0 and `frame_err` is 0.
- R2: A transaction whose first byte (MSB first, sampled on serial clock rising edges) has bit 7 = 0 and bit 6 = 0 is a write. If the second byte has bits 7:6 = 01, it is stored into register `addr[5:0]` and appears on `regs_o[8*addr +: 8]` after the 16th rising edge.
- R3: A first byte with bit 7 = 1 and bit 6 = 0 is a read. The register is driven on `sdo` MSB first, each bit changing after a serial clock falling edge, so bits 7..0 are valid before rising edges 9..16. `sdo` is 0 at all other times.
- R4: The bit counter wraps after 16 rising edges, and consecutive transactions need no gap or select signal.
- R5: A write whose address bit 6 is 1 (other than the 7Fh/FFh pattern) is discarded and sets `frame_err`. The flag stays set until a cold or warm reset.
- R6: A write whose data bits 7:6 differ from 01 is discarded and sets `frame_err`.
- R7: A read whose address bit 6 is 1 shifts out 00h and sets `frame_err`.
- R8: Whenever the last 16 received bits equal 7FFFh (address 7Fh, data FFh), the bit counter restarts, any read in progress ends and `frame_err` clears. This happens at any counter position, and all register values are kept.
- R9: A one-cycle pulse on `reg_clear` restores every register to its default except 00h, 01h and 18h.
- R10: When a write commits in the same clock cycle as a `reg_clear` pulse, the written value is kept in its register and every other non-spared register takes its default.
- R11: A write to 7Fh with data other than FFh stores nothing and sets `frame_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock that oversamples the serial wires |
| rst_n | input | 1 | Active-low cold reset |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host, sampled on sck rising edges |
| reg_clear | input | 1 | One-cycle register-default request |
| sdo | output | 1 | Serial read data, changes after sck falling edges |
| frame_err | output | 1 | Sticky framing-violation flag |
| regs_o | output | 512 | All 64 stored registers, register n at bits 8n+7:8n |

## Verification
The two functions that can fall in the same clock cycle are the commit of a serial write and a `reg_clear` pulse. The bench counts the cycles through the serial-clock synchroniser and raises `reg_clear` exactly in the cycle where the 16th rising edge is committed. It then judges the whole register image: the written register must hold the new value, and every other non-spared register must hold its default. The warm-reset pattern is also sent on a slipped counter, where it lands on top of a misaligned junk write, and the result must show no stored junk.

// File: rtl/csr_serial_slave.sv
module csr_serial_slave #(
  parameter int NREG = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              reg_clear,
  output logic              sdo,
  output logic              frame_err,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = $clog2(NREG);

  function automatic logic [7:0] dflt(int i);
    return {2'b01, 6'(i)};
  endfunction

  function automatic logic spared(int i);
    return i == 'h00 || i == 'h01 || i == 'h18;
  endfunction

  logic [2:0]  sck_s;
  logic [1:0]  sdi_s;
  logic [3:0]  cnt;
  logic [6:0]  sh;
  logic [7:0]  addr_q;
  logic [15:0] hist;
  logic [7:0]  rd_sh;
  logic        rd_act;
  logic [7:0]  regs [NREG];

  wire        rise      = sck_s[1] & ~sck_s[2];
  wire        fall      = ~sck_s[1] & sck_s[2];
  wire        bit_in    = sdi_s[1];
  wire [15:0] hist_n    = {hist[14:0], bit_in};
  wire [7:0]  byte_n    = {sh, bit_in};
  wire        warm      = rise && hist_n == 16'h7FFF;
  wire        addr_done = rise && cnt == 4'd7 && !warm;
  wire        data_done = rise && cnt == 4'd15 && !warm;
  wire        wr_ok     = !addr_q[6] && byte_n[7:6] == 2'b01;
  wire        wr_en     = data_done && !addr_q[7] && wr_ok;
  wire        wr_bad    = data_done && !addr_q[7] && !wr_ok;
  wire        rd_bad    = addr_done && byte_n[7] && byte_n[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck};
      sdi_s <= {sdi_s[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sh <= '0; addr_q <= '0; hist <= '0;
      rd_sh <= '0; rd_act <= 1'b0; sdo <= 1'b0; frame_err <= 1'b0;
    end else if (warm) begin
      cnt <= '0; hist <= '0; rd_act <= 1'b0; frame_err <= 1'b0;
    end else begin
      if (rise) begin
        cnt  <= cnt + 4'd1;
        hist <= hist_n;
        sh   <= byte_n[6:0];
      end
      if (addr_done) begin
        addr_q <= byte_n;
        if (byte_n[7]) begin
          rd_act <= 1'b1;
          rd_sh  <= byte_n[6] ? 8'h00 : regs[byte_n[IW-1:0]];
        end
      end
      if (data_done) rd_act <= 1'b0;
      if (fall) begin
        sdo <= rd_act ? rd_sh[7] : 1'b0;
        if (rd_act) rd_sh <= {rd_sh[6:0], 1'b0};
      end
      if (rd_bad || wr_bad) frame_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
    end else begin
      if (reg_clear)
        for (int i = 0; i < NREG; i++)
          if (!spared(i)) regs[i] <= dflt(i);
      if (wr_en) regs[addr_q[IW-1:0]] <= byte_n;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end
endmodule

module csr_serial_slave_chk #(
  parameter int NREG = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise,
  input logic              fall,
  input logic [3:0]        cnt,
  input logic              warm,
  input logic              wr_en,
  input logic              reg_clear,
  input logic              sdo,
  input logic              frame_err,
  input logic [NREG*8-1:0] regs_o
);
  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise && cnt == 4'd15 && !warm |=> cnt == 4'd0);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !warm |=> frame_err);
  // R3
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo));
  // R8
  warm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm && !reg_clear |=> $stable(regs_o));
  // R9
  spare_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clear && !wr_en |=> $stable(regs_o[7:0]));
  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !reg_clear |=> $stable(regs_o));
endmodule

bind csr_serial_slave csr_serial_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .cnt(cnt),
  .warm(warm), .wr_en(wr_en), .reg_clear(reg_clear), .sdo(sdo),
  .frame_err(frame_err), .regs_o(regs_o)
);

// File: tb/csr_serial_slave_tb.sv
`timescale 1ns/1ps
module csr_serial_slave_tb;
  localparam int NREG = 64;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sdi = 1'b0, reg_clear = 1'b0;
  logic sdo, frame_err;
  logic [NREG*8-1:0] regs_o;
  logic [7:0] model [NREG];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  csr_serial_slave #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .reg_clear(reg_clear),
    .sdo(sdo), .frame_err(frame_err), .regs_o(regs_o)
  );

  function automatic logic [7:0] dflt(int i);
    return {2'b01, 6'(i)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    int bad = -1;
    for (int i = 0; i < NREG; i++)
      if (bad < 0 && regs_o[i*8 +: 8] !== model[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, {24'd0, regs_o[bad*8 +: 8]}, {24'd0, model[bad]});
  endtask

  task automatic send_bit(input logic b, input bit clr, output logic got);
    @(negedge clk);
    sck = 1'b0;
    repeat (4) @(negedge clk);
    got = sdo;
    sdi = b;
    sck = 1'b1;
    repeat (2) @(negedge clk);
    reg_clear = clr;
    @(negedge clk);
    reg_clear = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] d, input bit clr,
                      output logic [15:0] got);
    for (int k = 0; k < 16; k++) begin
      logic b, s;
      b = (k < 8) ? a[7-k] : (a[7] ? 1'b0 : d[15-k]);
      send_bit(b, clr && k == 15, s);
      got[15-k] = s;
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    logic [15:0] g;
    xfer(a, d, 1'b0, g);
    if (!a[6] && d[7:6] == 2'b01) model[a[5:0]] = d;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, string req);
    logic [15:0] g;
    xfer(a, 8'h00, 1'b0, g);
    chk(g == {8'h00, exp}, req, {16'd0, g}, {16'd0, 8'h00, exp});
  endtask

  task automatic warm_reset();
    logic [15:0] g;
    xfer(8'h7F, 8'hFF, 1'b0, g);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] g;
    logic s;
    void'($urandom(32'd20250611));
    for (int i = 0; i < NREG; i++) model[i] = dflt(i);
    repeat (5) @(negedge clk);
    // R1 during and after reset
    chk_regs("R1 defaults in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0 && frame_err == 1'b0, "R1 outputs idle", {30'd0, sdo, frame_err}, 0);
    chk_regs("R1 defaults");

    // R2 write and R3 read
    do_write(8'h03, 8'h55);
    chk_regs("R2 write stored");
    do_read(8'h83, 8'h55, "R3 read back");
    do_read(8'h92, dflt(8'h12), "R3 read default");

    // R5 address bit 6 set
    do_write(8'h45, 8'h4A);
    chk(frame_err == 1'b1, "R5 err set", {31'd0, frame_err}, 1);
    chk_regs("R5 discarded");
    do_write(8'h07, 8'h63);
    chk(frame_err == 1'b1, "R5 err sticky", {31'd0, frame_err}, 1);
    chk_regs("R5 later write ok");

    // R8 aligned warm reset
    warm_reset();
    chk(frame_err == 1'b0, "R8 err cleared", {31'd0, frame_err}, 0);
    chk_regs("R8 regs kept");

    // R6 bad data header
    do_write(8'h06, 8'h86);
    chk(frame_err == 1'b1, "R6 err set", {31'd0, frame_err}, 1);
    chk_regs("R6 discarded");
    warm_reset();

    // R7 read with bit 6 set
    do_read(8'hC2, 8'h00, "R7 zero data");
    chk(frame_err == 1'b1, "R7 err set", {31'd0, frame_err}, 1);
    warm_reset();

    // R11 non-FF write to 7Fh
    do_write(8'h7F, 8'h41);
    chk(frame_err == 1'b1, "R11 err set", {31'd0, frame_err}, 1);
    chk_regs("R11 nothing stored");

    // R8 slipped counter
    for (int k = 0; k < 3; k++) send_bit(1'b0, 1'b0, s);
    warm_reset();
    chk(frame_err == 1'b0, "R8 slip err cleared", {31'd0, frame_err}, 0);
    chk_regs("R8 slip regs kept");
    do_read(8'h83, 8'h55, "R8 realigned read");

    // R9 register reset with spared entries
    do_write(8'h00, 8'h7A);
    do_write(8'h01, 8'h7B);
    do_write(8'h18, 8'h7C);
    do_write(8'h09, 8'h7D);
    @(negedge clk); reg_clear = 1'b1;
    @(negedge clk); reg_clear = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (i != 'h00 && i != 'h01 && i != 'h18) model[i] = dflt(i);
    @(negedge clk);
    chk_regs("R9 reset spares 00 01 18");

    // R10 clear in the commit cycle
    do_write(8'h09, 8'h71);
    xfer(8'h0A, 8'h6E, 1'b1, g);
    for (int i = 0; i < NREG; i++)
      if (i != 'h00 && i != 'h01 && i != 'h18) model[i] = dflt(i);
    model[8'h0A] = 8'h6E;
    chk_regs("R10 write wins over clear");

    // R4 random back-to-back traffic
    for (int n = 0; n < 120; n++) begin
      logic [5:0] a;
      a = 6'($urandom);
      if ($urandom % 2) do_write({2'b00, a}, {2'b01, 6'($urandom)});
      else do_read({2'b10, a}, model[a], "R4 back-to-back read");
    end
    chk_regs("R4 random image");
    chk(frame_err == 1'b0, "R4 no spurious err", {31'd0, frame_err}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule